// File: doc/BRIEF.md
# DMA Channel Completion Result and Interrupt Unit

This unit sits beside the data movers of a multi-channel DMA engine and collects their completion reports. Each channel engine offers a completion through a valid/ready handshake, with an error flag. The unit stores each completion in a small per-channel result queue. It marks the channel as holding a result, and drives one interrupt line toward the host while any channel holds an unread result whose interrupt is enabled.

The host uses a plain register port. It reads per-channel status, reads result words (each read removes the oldest result), sets per-channel configuration and reads a summary interrupt register. A write to a channel's flush register sends a one-cycle abort pulse to that channel's engine. When flush reporting is enabled, the write also queues a flushed result. A channel whose queue is full holds its engine back until the host frees a slot.

Top module: `dma_rslt_irq`

## Requirements
- R1: After reset, `irq` is 0, every `ev_ready` bit is 1, and every status, result, configuration and interrupt-summary read returns 0.
- R2: An accepted completion on channel i queues a result word with bit 31 (valid) set, bit 1 (transfer done) set, bit 2 clear, and bit 3 set exactly when `ev_err` was 1. The status word at 0x200+4i then has bit 1 set.
- R3: A read at 0x40+4i returns the oldest result of channel i and removes it. Results come out in arrival order, two at most are held, and status bit 1 clears when none remain. A read of an empty channel returns 0 and changes nothing.
- R4: While channel i holds two unread results, `ev_ready[i]` is 0 and a held completion is not taken. It is taken in the cycle after a read frees a slot.
- R5: The interrupt summary register at 0x3C0 has bit i set exactly when channel i holds a result and its interrupt enable is set. `irq` is the OR of those bits.
- R6: The configuration register at 0x300+4i reads back bits [1:0]: bit 0 enables the interrupt and bit 1 enables flush reporting. Writing 0 masks the channel's interrupt without dropping its results.
- R7: Any write to 0x80+4i, whatever its data, drives `abort[i]` high for exactly the one cycle after the write.
- R8: A flush write with flush reporting enabled queues the word 0x80000004 (valid and flush, no done). With flush reporting disabled, no result is queued.
- R9: A flush result that finds the queue full waits, is queued as soon as a slot frees, and comes before any engine completion. `ev_ready[i]` stays 0 while it waits.
- R10: Channels are independent: activity on one channel changes no other channel's results, status or abort line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | NCH | Per-channel completion offer, held until accepted |
| ev_err | input | NCH | Per-channel error flag, valid with `ev_valid` |
| ev_ready | output | NCH | Per-channel acceptance; 0 stalls the engine |
| abort | output | NCH | Per-channel one-cycle abort toward the engine |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops a result when a result word is addressed) |
| reg_addr | input | ADDR_W | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from the address |
| irq | output | 1 | Interrupt toward the host |

## Verification
The assertions assume that an engine holds `ev_valid` and `ev_err` steady until `ev_ready` accepts the offer. They also assume that reads and writes are single-cycle strobes sampled at the rising edge. The bench drives every input on the falling edge. Where it offers a completion into a full queue, it keeps the offer raised across the stall and drops it only in the cycle after acceptance. It never asserts a read and a write together.

// File: rtl/dma_rslt_pkg.sv
package dma_rslt_pkg;

    typedef struct packed {
        logic err;
        logic flush;
        logic done;
    } rflags_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RES,
        RG_FLUSH,
        RG_STAT,
        RG_CONF,
        RG_IRQ
    } region_e;

    localparam int W_VALID_BIT = 31;
    localparam int W_ERR_BIT   = 3;
    localparam int W_FLUSH_BIT = 2;
    localparam int W_DONE_BIT  = 1;
    localparam int ST_HAVE_BIT = 1;

    function automatic logic [31:0] mk_word(input logic have, input rflags_t f);
        logic [31:0] w;
        w = '0;
        if (have) begin
            w[W_VALID_BIT] = 1'b1;
            w[W_ERR_BIT]   = f.err;
            w[W_FLUSH_BIT] = f.flush;
            w[W_DONE_BIT]  = f.done;
        end
        return w;
    endfunction

endpackage

// File: rtl/dma_rslt_dec.sv
module dma_rslt_dec
    import dma_rslt_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [CH_W-1:0]   idx
);
    localparam int PG_W = ADDR_W - 6;
    localparam logic [PG_W-1:0] PG_RES   = PG_W'(1);
    localparam logic [PG_W-1:0] PG_FLUSH = PG_W'(2);
    localparam logic [PG_W-1:0] PG_STAT  = PG_W'(8);
    localparam logic [PG_W-1:0] PG_CONF  = PG_W'(12);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(12'h3C0);

    logic [PG_W-1:0] page;
    logic [3:0]      slot;
    logic            in_range;

    always_comb begin
        page     = addr[ADDR_W-1:6];
        slot     = addr[5:2];
        in_range = ({28'b0, slot} < NCH) && (addr[1:0] == 2'b00);
        idx      = addr[2 +: CH_W];
        region   = RG_NONE;
        if (addr == A_IRQ)                      region = RG_IRQ;
        else if (in_range && page == PG_RES)    region = RG_RES;
        else if (in_range && page == PG_FLUSH)  region = RG_FLUSH;
        else if (in_range && page == PG_STAT)   region = RG_STAT;
        else if (in_range && page == PG_CONF)   region = RG_CONF;
    end
endmodule

// File: rtl/dma_rslt_chan.sv
module dma_rslt_chan
    import dma_rslt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_valid,
    input  logic       ev_err,
    output logic       ev_ready,
    input  logic       wr_cfg,
    input  logic       wr_flush,
    input  logic [1:0] wdata,
    input  logic       pop,
    output rflags_t    head,
    output logic       have,
    output logic [1:0] cfg,
    output logic       abort,
    output logic       irq_bit
);
    localparam int DEPTH = 2;

    typedef struct packed {
        rflags_t [DEPTH-1:0] slot;
        logic                hd;
        logic [1:0]          cnt;
        logic [1:0]          cfg;
        logic                fpend;
        logic                abort;
    } cstate_t;

    cstate_t s_d, s_q;
    logic    space, pop_ok, push_fl, push_ev, tail;

    always_comb begin
        s_d      = s_q;
        s_d.abort = 1'b0;
        space    = (s_q.cnt < 2'(DEPTH));
        pop_ok   = pop && (s_q.cnt != 2'd0);
        push_fl  = s_q.fpend && space;
        ev_ready = space && !s_q.fpend;
        push_ev  = ev_valid && ev_ready;
        tail     = s_q.hd ^ s_q.cnt[0];

        if (wr_cfg) s_d.cfg = wdata;
        if (push_fl) begin
            s_d.slot[tail] = '{err: 1'b0, flush: 1'b1, done: 1'b0};
            s_d.fpend      = 1'b0;
        end else if (push_ev) begin
            s_d.slot[tail] = '{err: ev_err, flush: 1'b0, done: 1'b1};
        end
        if (wr_flush) begin
            s_d.abort = 1'b1;
            if (s_q.cfg[1]) s_d.fpend = 1'b1;
        end
        if (pop_ok) s_d.hd = ~s_q.hd;
        s_d.cnt = s_q.cnt + 2'(push_fl || push_ev) - 2'(pop_ok);

        head    = s_q.slot[s_q.hd];
        have    = (s_q.cnt != 2'd0);
        cfg     = s_q.cfg;
        abort   = s_q.abort;
        irq_bit = have && s_q.cfg[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= 2'(DEPTH));
    p_stall_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && s_q.cnt == 2'(DEPTH)) |-> !ev_ready);
    p_offer_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> ev_valid);
    p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flush |=> abort);
    p_flush_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fpend |-> !ev_ready);
endmodule

// File: rtl/dma_rslt_irq.sv
module dma_rslt_irq
    import dma_rslt_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ev_valid,
    input  logic [NCH-1:0]    ev_err,
    output logic [NCH-1:0]    ev_ready,
    output logic [NCH-1:0]    abort,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CH_W = $clog2(NCH);

    region_e         region;
    logic [CH_W-1:0] idx;
    rflags_t         head_a [NCH];
    logic [1:0]      cfg_a  [NCH];
    logic [NCH-1:0]  have_v, irq_v;

    dma_rslt_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr(reg_addr), .region(region), .idx(idx)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = (idx == CH_W'(i));
        dma_rslt_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_valid (ev_valid[i]),
            .ev_err   (ev_err[i]),
            .ev_ready (ev_ready[i]),
            .wr_cfg   (reg_wr && region == RG_CONF && hit),
            .wr_flush (reg_wr && region == RG_FLUSH && hit),
            .wdata    (reg_wdata[1:0]),
            .pop      (reg_rd && region == RG_RES && hit),
            .head     (head_a[i]),
            .have     (have_v[i]),
            .cfg      (cfg_a[i]),
            .abort    (abort[i]),
            .irq_bit  (irq_v[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (region)
            RG_RES:  reg_rdata = mk_word(have_v[idx], head_a[idx]);
            RG_STAT: reg_rdata[ST_HAVE_BIT] = have_v[idx];
            RG_CONF: reg_rdata[1:0] = cfg_a[idx];
            RG_IRQ:  reg_rdata[NCH-1:0] = irq_v;
            default: reg_rdata = '0;
        endcase
        irq = |irq_v;
    end

    p_irq_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (have_v != '0));
endmodule

// File: tb/dma_rslt_irq_tb.sv
module dma_rslt_irq_tb;
    localparam int NCH = 16;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ev_valid = '0, ev_err = '0, ev_ready, abort;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq;
    int checks = 0, errors = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_rslt_irq u_dut (.*);

    function automatic logic [11:0] a_res(int ch);  return 12'(12'h040 + ch*4); endfunction
    function automatic logic [11:0] a_fl(int ch);   return 12'(12'h080 + ch*4); endfunction
    function automatic logic [11:0] a_st(int ch);   return 12'(12'h200 + ch*4); endfunction
    function automatic logic [11:0] a_cf(int ch);   return 12'(12'h300 + ch*4); endfunction
    localparam logic [11:0] A_IRQ = 12'h3C0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic complete(int ch, logic e);
        @(negedge clk); ev_valid[ch] = 1'b1; ev_err[ch] = e;
        @(negedge clk); ev_valid[ch] = 1'b0; ev_err[ch] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq), 0);
        check("R1 ev_ready", 32'(ev_ready), 32'hFFFF);
        rd(A_IRQ, d);    check("R1 irq summary", d, 0);
        rd(a_st(3), d);  check("R1 status", d, 0);
        rd(a_res(3), d); check("R1 result", d, 0);
        rd(a_cf(3), d);  check("R1 config", d, 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        wr(a_cf(0), 32'h1);
        rd(a_cf(0), d);  check("R6 config readback", d, 1);
        complete(0, 1'b0);
        rd(a_st(0), d);  check("R2 status have", d, 32'h2);
        check("R5 irq high", 32'(irq), 1);
        rd(A_IRQ, d);    check("R5 summary bit0", d, 32'h1);
        rd(a_res(0), d); check("R2 done word", d, 32'h80000002);
        rd(a_st(0), d);  check("R3 status clears", d, 0);
        check("R5 irq low", 32'(irq), 0);
        rd(a_res(0), d); check("R3 empty read", d, 0);
        rd(a_st(0), d);  check("R3 empty read no effect", d, 0);
    endtask

    task automatic t_order_full();
        logic [31:0] d;
        complete(1, 1'b1);
        complete(1, 1'b0);
        check("R4 ready low when full", 32'(ev_ready[1]), 0);
        @(negedge clk); ev_valid[1] = 1'b1; ev_err[1] = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 still stalled", 32'(ev_ready[1]), 0);
        rd(a_res(1), d); check("R3 first is error", d, 32'h8000000A);
        @(negedge clk); ev_valid[1] = 1'b0; ev_err[1] = 1'b0;
        rd(a_res(1), d); check("R3 second in order", d, 32'h80000002);
        rd(a_res(1), d); check("R4 held completion taken", d, 32'h8000000A);
        rd(a_res(1), d); check("R4 taken once only", d, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        complete(5, 1'b0);
        check("R6 masked irq low", 32'(irq), 0);
        rd(A_IRQ, d);    check("R5 summary masked", d, 0);
        rd(a_st(5), d);  check("R6 result kept", d, 32'h2);
        wr(a_cf(5), 32'h1);
        check("R5 irq after enable", 32'(irq), 1);
        rd(A_IRQ, d);    check("R5 summary bit5", d, 32'h20);
        wr(a_cf(5), 32'h0);
        check("R6 write zero masks", 32'(irq), 0);
        rd(a_res(5), d); check("R6 result survives mask", d, 32'h80000002);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        wr(a_cf(7), 32'h1);
        @(negedge clk); reg_addr = a_fl(7); reg_wdata = 32'hDEAD0000; reg_wr = 1'b1;
        @(posedge clk); #1 check("R7 abort pulse", 32'(abort), 32'h80);
        @(negedge clk); reg_wr = 1'b0;
        @(posedge clk); #1 check("R7 abort one cycle", 32'(abort), 0);
        rd(a_st(7), d);  check("R8 no result without report", d, 0);
        wr(a_cf(7), 32'h3);
        wr(a_fl(7), 32'h0);
        rd(a_res(7), d); check("R8 flush word", d, 32'h80000004);
        check("R10 no abort elsewhere", 32'(abort), 0);
    endtask

    task automatic t_flush_pend();
        logic [31:0] d;
        wr(a_cf(2), 32'h3);
        complete(2, 1'b0);
        complete(2, 1'b0);
        @(negedge clk); ev_valid[2] = 1'b1;
        wr(a_fl(2), 32'h1);
        rd(a_res(2), d); check("R9 first pop", d, 32'h80000002);
        check("R9 ready low while flush waits", 32'(ev_ready[2]), 0);
        rd(a_res(2), d); check("R9 second pop", d, 32'h80000002);
        @(negedge clk); ev_valid[2] = 1'b0;
        rd(a_res(2), d); check("R9 flush before completion", d, 32'h80000004);
        rd(a_res(2), d); check("R9 completion after flush", d, 32'h80000002);
    endtask

    task automatic t_indep();
        logic [31:0] d;
        complete(9, 1'b1);
        rd(a_st(8), d);  check("R10 neighbour status", d, 0);
        rd(a_res(10), d); check("R10 neighbour result", d, 0);
        rd(a_res(9), d); check("R10 own result", d, 32'h8000000A);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_order_full();
        t_mask();
        t_flush();
        t_flush_pend();
        t_indep();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule